// File: doc/BRIEF.md
# Flyback Cell Balancer Switching Sequencer

This block drives the two gate enables of one bidirectional flyback balancing channel. The primary gate switches the winding on the cell side and the secondary gate switches the winding on the stack side. A two-bit mode code selects one of four actions: idle, charging the cell, synchronous discharge, or nonsynchronous discharge. The sequencer then runs ramp-up and ramp-down phases in a loop for as long as that code stays valid and the channel is enabled. The analog comparators are modelled as two digital flags. One flag reports that the winding current has reached its peak and the other reports that it has fallen to zero.

Two programmable counters guard the loop. A volt-second clamp limits each secondary interval, and in nonsynchronous discharge it sets how long the diode conducts with the secondary gate held off. A watchdog limits each primary interval. If the primary interval expires, the channel shuts down until the mode code changes or the channel is disabled. One dead cycle separates every pair of phases, so the two gates are never on together.

Top module: `fbal_switch_seq`

## Requirements
- R1: During reset, and whenever the mode code is 00, both gates are low.
- R2: Mode code 11 (charge) first drives the secondary gate until `peak_hit`. It then drives the primary gate until `zero_hit`, and the loop repeats.
- R3: Mode code 10 (synchronous discharge) first drives the primary gate until `peak_hit`. It then drives the secondary gate until `zero_hit`, and the loop repeats. `peak_hit` has no effect while the secondary is on.
- R4: Mode code 01 (nonsynchronous discharge) never raises the secondary gate and ignores `zero_hit`. After the primary ends on `peak_hit`, both gates stay low for one dead cycle, then for `clamp_limit` cycles, then for one more dead cycle, and then the primary turns on again.
- R5: No secondary interval lasts more than `clamp_limit` cycles, where a limit of 0 counts as 1. If the interval's own flag has not arrived by then, the clamp ends it and the loop moves on to the primary phase.
- R6: The two gates are never high in the same cycle. A falling gate is followed by at least one cycle with both gates low before the other gate rises.
- R7: If `enable` is low, or the mode code differs from its value in the previous cycle, both gates are low after the next clock edge. If the code is then held for one cycle with `enable` high, the loop restarts from its first phase.
- R8: If the primary interval's ending flag has not arrived after `wdog_limit` cycles (a limit of 0 counts as 1), the primary gate goes low. Both gates then stay low until the mode code changes or `enable` falls.
- R9: If an interval's ending flag arrives in the same cycle in which its counter expires, the flag decides the next step. In particular, a primary interval that ends on its flag in its last allowed cycle continues the loop and does not shut down.
- R10: Starting from idle, charge begins with the secondary gate and both discharge modes begin with the primary gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable |
| mode | input | 2 | 00 idle, 01 nonsynchronous discharge, 10 synchronous discharge, 11 charge |
| peak_hit | input | 1 | Winding current has reached its peak |
| zero_hit | input | 1 | Winding current has fallen to zero |
| clamp_limit | input | CLAMP_W | Longest secondary interval, in cycles |
| wdog_limit | input | WDOG_W | Longest primary interval, in cycles |
| pri_gate | output | 1 | Primary switch enable |
| sec_gate | output | 1 | Secondary switch enable |

## Verification
An interval can end on its comparator flag in the same cycle in which its counter runs out. For the primary this matters, because the flag continues the loop while expiry shuts the channel down. The bench holds `peak_hit` low in synchronous discharge until the primary has been on for exactly `wdog_limit` cycles, then raises it in that last cycle. The result is judged at the gates. A dead cycle followed by a rising secondary means the flag won; gates that stay low mean the watchdog took over. A separate run without the flag checks that the shutdown does happen and that it persists.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_DIS_NSYNC = 2'b01,
        MODE_DIS_SYNC  = 2'b10,
        MODE_CHARGE    = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRI  = 3'd1,
        ST_SEC  = 3'd2,
        ST_FREE = 3'd3,   // secondary conducting through diode, gate held off
        ST_DEAD = 3'd4,
        ST_HALT = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        seq_state_e after;  // phase entered once the dead cycle ends
        logic       pri;
        logic       sec;
    } seq_t;

endpackage

// File: rtl/fbs_phase_timer.sv
module fbs_phase_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        expire  = run && (cnt_inc >= {1'b0, limit});
        if (!run) begin
            cnt_d = '0;
        end else if (expire) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_inc[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0) || run); // R5
endmodule

// File: rtl/fbs_mode_track.sv
module fbs_mode_track
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode_in,
    output mode_e      mode_q,
    output logic       stable
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_e'(mode_in);
        stable = enable && (mode_e'(mode_in) == mode_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/fbal_switch_seq.sv
module fbal_switch_seq
    import fbs_pkg::*;
#(
    parameter int CLAMP_W = 10,
    parameter int WDOG_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         mode,
    input  logic               peak_hit,
    input  logic               zero_hit,
    input  logic [CLAMP_W-1:0] clamp_limit,
    input  logic [WDOG_W-1:0]  wdog_limit,
    output logic               pri_gate,
    output logic               sec_gate
);
    mode_e cur_mode;
    logic  stable;
    logic  clamp_run, clamp_exp;
    logic  wdog_run, wdog_exp;
    logic  term_pri, term_sec;
    seq_t  s_d, s_q;

    fbs_mode_track u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode_in (mode),
        .mode_q  (cur_mode),
        .stable  (stable)
    );

    fbs_phase_timer #(.W(CLAMP_W)) u_clamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (clamp_run),
        .limit  (clamp_limit),
        .expire (clamp_exp)
    );

    fbs_phase_timer #(.W(WDOG_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wdog_run),
        .limit  (wdog_limit),
        .expire (wdog_exp)
    );

    always_comb begin
        clamp_run = (s_q.state == ST_SEC) || (s_q.state == ST_FREE);
        wdog_run  = (s_q.state == ST_PRI);
        // primary ends on zero when charging, on peak when discharging
        term_pri  = (cur_mode == MODE_CHARGE) ? zero_hit : peak_hit;
        term_sec  = (cur_mode == MODE_CHARGE) ? peak_hit : zero_hit;

        s_d = s_q;
        if (!stable) begin
            s_d.state = ST_IDLE;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (cur_mode == MODE_CHARGE) begin
                        s_d.state = ST_SEC;
                    end else if (cur_mode != MODE_OFF) begin
                        s_d.state = ST_PRI;
                    end
                end
                ST_PRI: begin
                    if (term_pri) begin
                        s_d.state = ST_DEAD;
                        s_d.after = (cur_mode == MODE_DIS_NSYNC) ? ST_FREE : ST_SEC;
                        if (cur_mode == MODE_CHARGE) begin
                            s_d.after = ST_SEC;
                        end
                    end else if (wdog_exp) begin
                        s_d.state = ST_HALT;
                    end
                end
                ST_SEC: begin
                    if (term_sec || clamp_exp) begin
                        s_d.state = ST_DEAD;
                        s_d.after = ST_PRI;
                    end
                end
                ST_FREE: begin
                    if (clamp_exp) begin
                        s_d.state = ST_DEAD;
                        s_d.after = ST_PRI;
                    end
                end
                ST_DEAD: begin
                    s_d.state = s_q.after;
                end
                ST_HALT: begin
                    s_d.state = ST_HALT;
                end
                default: begin
                    s_d.state = ST_IDLE;
                end
            endcase
        end
        s_d.pri = (s_d.state == ST_PRI);
        s_d.sec = (s_d.state == ST_SEC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, after: ST_PRI, pri: 1'b0, sec: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pri_gate = s_q.pri;
    assign sec_gate = s_q.sec;

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_gate && sec_gate)); // R6
    AST_DEAD_AFTER_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        pri_gate |=> !sec_gate); // R6
    AST_DEAD_AFTER_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        sec_gate |=> !pri_gate); // R6
    AST_NSYNC_NO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        sec_gate |-> (cur_mode != MODE_DIS_NSYNC)); // R4
    AST_UNSTABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stable |=> (!pri_gate && !sec_gate)); // R7
    AST_CLAMP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_exp |=> !sec_gate); // R5
    AST_WDOG_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_exp && !term_pri) |=> !pri_gate); // R8
    AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (stable && wdog_run && wdog_exp && term_pri) |=> (s_q.state == ST_DEAD)); // R9
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_OFF) |-> (!pri_gate && !sec_gate)); // R1
endmodule

// File: tb/sim_fbal_switch_seq.sv
module sim_fbal_switch_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       peak_hit = 1'b0;
    logic       zero_hit = 1'b0;
    logic [9:0] clamp_limit = 10'd4;
    logic [9:0] wdog_limit = 10'd6;
    logic       pri_gate, sec_gate;
    int         errors = 0;
    int         checks = 0;

    always #5 clk = ~clk;

    fbal_switch_seq #(.CLAMP_W(10), .WDOG_W(10)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode        (mode),
        .peak_hit    (peak_hit),
        .zero_hit    (zero_hit),
        .clamp_limit (clamp_limit),
        .wdog_limit  (wdog_limit),
        .pri_gate    (pri_gate),
        .sec_gate    (sec_gate)
    );

    // {mode[1:0], peak_hit, zero_hit, expected pri, expected sec}; clamp 4, watchdog 6
    localparam int NV = 37;
    localparam logic [5:0] VEC [NV] = '{
        6'b00_00_00, // R1 idle
        6'b11_00_00, // R7 code change
        6'b11_00_01, // R10 R2 charge starts on secondary
        6'b11_00_01,
        6'b11_10_00, // R2 peak ends secondary, dead
        6'b11_00_10, // R2 primary
        6'b11_00_10,
        6'b11_01_00, // R2 zero ends primary
        6'b11_00_01,
        6'b11_00_01,
        6'b11_00_01,
        6'b11_00_01,
        6'b11_00_00, // R5 clamp ends secondary after 4 cycles
        6'b11_00_10, // R5 primary follows
        6'b10_00_00, // R7 code change drops gates
        6'b10_00_10, // R10 R3 discharge starts on primary
        6'b10_10_00, // R3
        6'b10_00_01, // R3
        6'b10_01_00,
        6'b10_00_10,
        6'b10_10_00,
        6'b10_00_01,
        6'b10_10_01, // R3 peak has no effect on secondary
        6'b10_01_00,
        6'b10_00_10,
        6'b01_00_00, // R7
        6'b01_00_10, // R4 primary first
        6'b01_01_10, // R4 zero ignored
        6'b01_10_00, // R4
        6'b01_00_00, // R4 secondary never on
        6'b01_01_00,
        6'b01_01_00,
        6'b01_00_00,
        6'b01_00_00,
        6'b01_00_10, // R4 primary again after clamp
        6'b00_00_00, // R1
        6'b00_00_00
    };

    task automatic check(input logic ep, input logic es, input string req);
        checks++;
        if (pri_gate !== ep || sec_gate !== es) begin
            errors++;
            $display("FAIL %s: pri/sec=%b%b expected %b%b at %0t", req, pri_gate, sec_gate, ep, es, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][5:4];
            peak_hit = VEC[i][3];
            zero_hit = VEC[i][2];
            step();
            check(VEC[i][1], VEC[i][0], "vector R1-R7 R10 table");
        end
        peak_hit = 1'b0;
        zero_hit = 1'b0;

        // R8: synchronous discharge with no peak flag
        mode = 2'b10;
        step();
        check(1'b0, 1'b0, "R7 change");
        for (int k = 0; k < 6; k++) begin
            step();
            check(1'b1, 1'b0, "R8 primary within limit");
        end
        step();
        check(1'b0, 1'b0, "R8 watchdog cut");
        for (int k = 0; k < 4; k++) begin
            step();
            check(1'b0, 1'b0, "R8 stays off");
        end

        // R9: flag in the last allowed primary cycle
        mode = 2'b00;
        step();
        mode = 2'b10;
        step();
        check(1'b0, 1'b0, "R7 idle");
        for (int k = 0; k < 6; k++) begin
            step();
            check(1'b1, 1'b0, "R9 primary");
        end
        peak_hit = 1'b1;
        step();
        peak_hit = 1'b0;
        check(1'b0, 1'b0, "R9 dead cycle");
        step();
        check(1'b0, 1'b1, "R9 flag wins, secondary on");

        // R7: disable mid phase, then resume
        enable = 1'b0;
        step();
        check(1'b0, 1'b0, "R7 disable");
        enable = 1'b1;
        step();
        check(1'b1, 1'b0, "R7 restart");

        // R5: clamp limit 0 counts as 1
        clamp_limit = 10'd0;
        mode = 2'b11;
        step();
        check(1'b0, 1'b0, "R7 change");
        step();
        check(1'b0, 1'b1, "R5 secondary one cycle");
        step();
        check(1'b0, 1'b0, "R5 clamp 0 ends");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule